// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits between a single hardwired interrupt line and the processor core. It remembers a request as soon as the line is seen high, but starts servicing it only on a cycle where the core signals that an instruction has just completed. It then asks the core to save its register context, waits for the core to confirm, and enters supervisor mode.

Next it runs an acknowledge cycle on the bus. The interrupting device answers with an 8-bit vector number. If no device answers within a bounded window, a fixed spurious vector is used instead. The vector number is scaled by the entry size and added to the table base. The block reads that entry from a synchronous-read vector table and presents the stored handler start address to the core for one cycle.

The block stays in service until the core signals return-from-interrupt, which drops it back to user mode. Requests seen while a vector is being acquired are masked. Requests recorded during service, or still held on the line, compete again after the return.

Top module: `vack_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `save_req_o`, `iack_o`, `tbl_rd_o`, `handler_valid_o` and `supervisor_o` are all 0 (user mode).
- R2: A high `irq_req_i` sampled while the block is idle or in service is remembered until it is accepted, even if the line falls again before any instruction completes.
- R3: A pending request is accepted only on a cycle where `insn_done_i` is 1. A request that is sampled high on that same cycle counts as pending. `save_req_o` becomes 1 in the following cycle and stays 1 until `save_done_i` is seen.
- R4: On the cycle after `save_done_i` is sampled with `save_req_o` high, `save_req_o` is 0 and both `supervisor_o` and `iack_o` are 1.
- R5: `iack_o` stays high until `iack_valid_i` is sampled high. The `iack_vec_i` value sampled with it becomes the vector, and `iack_o` is 0 in the next cycle.
- R6: `iack_o` is high for at most ACK_LIMIT (16) consecutive cycles. If no answer arrives in those cycles, the spurious vector SPUR_VEC (0x18) is used. An answer in the 16th cycle still takes priority.
- R7: In the cycle after `iack_o` falls, `tbl_rd_o` is high for exactly one cycle with `tbl_addr_o` = TABLE_BASE + 4 × vector (TABLE_BASE = 0x1000).
- R8: The table returns data one cycle after the `tbl_rd_o` cycle. In the cycle after that, `handler_valid_o` is high for exactly one cycle and `handler_addr_o` carries that data.
- R9: A request that is high only between acceptance and handler delivery is dropped. After the return, no second acceptance follows from it.
- R10: `rti_i` in service makes `supervisor_o` 0 in the next cycle and returns the block to idle. A request recorded in service, or one still held high, is then accepted at the next `insn_done_i`.
- R11: `rti_i` while idle or while a vector is being acquired has no effect on `supervisor_o` or on the acknowledge sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Hardwired-level interrupt request line |
| insn_done_i | input | 1 | Core reports completion of the current instruction |
| save_req_o | output | 1 | Request to the core to save its register context |
| save_done_i | input | 1 | Core has finished saving context |
| supervisor_o | output | 1 | Processor mode: 1 supervisor, 0 user |
| iack_o | output | 1 | Acknowledge bus cycle in progress |
| iack_valid_i | input | 1 | Device answers the acknowledge cycle |
| iack_vec_i | input | VEC_W (8) | Vector number driven by the device |
| tbl_rd_o | output | 1 | Vector table read strobe |
| tbl_addr_o | output | ADDR_W (32) | Vector table entry address |
| tbl_rdata_i | input | ADDR_W (32) | Entry data, valid one cycle after the read strobe |
| handler_valid_o | output | 1 | Handler address is valid this cycle |
| handler_addr_o | output | ADDR_W (32) | Handler start address for the core |
| rti_i | input | 1 | Return-from-interrupt executed |

## Verification
Two events can land on the same cycle: a device answer and the expiry of the acknowledge window. The bench holds the answer back until the 16th acknowledge cycle and drives it exactly there. It then checks that the table read uses the device's vector (0xFF, address 0x13FC) and not the spurious one. A separate run gives no answer at all, counts the acknowledge cycles (expected 16) and expects the spurious entry address 0x1060. Return-from-interrupt arriving together with a held request line is also driven. The bench checks that nothing restarts until the next instruction boundary.

// File: rtl/vack_pkg.sv
package vack_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_ACK   = 3'd2,
    ST_FETCH = 3'd3,
    ST_SERVE = 3'd4
  } vack_state_t;

endpackage

// File: rtl/vack_pend_latch.sv
// Remembers a level request while capture is allowed; cleared on acceptance.
module vack_pend_latch (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic capture_en_i,
  input  logic clear_i,
  output logic pending_o
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      held_q <= 1'b0;
    end else if (capture_en_i && irq_i) begin
      held_q <= 1'b1;
    end
  end

  // A request seen in the accepting cycle itself also counts.
  assign pending_o = held_q | (capture_en_i & irq_i);

endmodule

// File: rtl/vack_ack_window.sv
// Bounds the acknowledge cycle and selects device or spurious vector.
module vack_ack_window #(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned LIMIT    = 16,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             active_i,
  input  logic             ans_valid_i,
  input  logic [VEC_W-1:0] ans_vec_i,
  output logic             done_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (cnt_q == LAST);
  // Device answer wins over expiry in the same cycle.
  assign done_o = active_i && (ans_valid_i || expire);
  assign vec_o  = ans_valid_i ? ans_vec_i : SPUR_VEC;

  always_ff @(posedge clk) begin
    if (rst || arm_i) begin
      cnt_q <= '0;
    end else if (active_i && !done_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/vack_table_fetch.sv
// Forms the table address and carries the synchronous read to the core.
module vack_table_fetch #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned ENTRY_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE  = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] rdata_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              landing_o,
  output logic              hvalid_o,
  output logic [ADDR_W-1:0] haddr_o
);

  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_o     <= 1'b0;
      addr_o   <= '0;
      wait_q   <= 1'b0;
      hvalid_o <= 1'b0;
      haddr_o  <= '0;
    end else begin
      rd_o     <= launch_i;
      wait_q   <= rd_o;
      hvalid_o <= wait_q;
      if (launch_i) begin
        addr_o <= BASE + (ADDR_W'(vec_i) << SHIFT);
      end
      if (wait_q) begin
        haddr_o <= rdata_i;
      end
    end
  end

  assign landing_o = wait_q;

endmodule

// File: rtl/vack_ctrl.sv
module vack_ctrl #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned ENTRY_BYTES = 4,
  parameter int unsigned ACK_LIMIT   = 16,
  parameter logic [VEC_W-1:0]  SPUR_VEC   = 8'h18,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req_i,
  input  logic              insn_done_i,
  output logic              save_req_o,
  input  logic              save_done_i,
  output logic              supervisor_o,
  output logic              iack_o,
  input  logic              iack_valid_i,
  input  logic [VEC_W-1:0]  iack_vec_i,
  output logic              tbl_rd_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  input  logic [ADDR_W-1:0] tbl_rdata_i,
  output logic              handler_valid_o,
  output logic [ADDR_W-1:0] handler_addr_o,
  input  logic              rti_i
);

  import vack_pkg::*;

  vack_state_t      st_q;
  logic             pending;
  logic             capture_en;
  logic             accept;
  logic             win_done;
  logic [VEC_W-1:0] win_vec;
  logic             landing;

  // Requests are recorded only while idle or in service (masked otherwise).
  assign capture_en = (st_q == ST_IDLE) || (st_q == ST_SERVE);
  assign accept     = (st_q == ST_IDLE) && pending && insn_done_i;

  vack_pend_latch u_pend (
    .clk          (clk),
    .rst          (rst),
    .irq_i        (irq_req_i),
    .capture_en_i (capture_en),
    .clear_i      (accept),
    .pending_o    (pending)
  );

  vack_ack_window #(
    .VEC_W    (VEC_W),
    .LIMIT    (ACK_LIMIT),
    .SPUR_VEC (SPUR_VEC)
  ) u_win (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (st_q == ST_SAVE),
    .active_i    (st_q == ST_ACK),
    .ans_valid_i (iack_valid_i),
    .ans_vec_i   (iack_vec_i),
    .done_o      (win_done),
    .vec_o       (win_vec)
  );

  vack_table_fetch #(
    .ADDR_W      (ADDR_W),
    .VEC_W       (VEC_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .BASE        (TABLE_BASE)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .launch_i  (win_done),
    .vec_i     (win_vec),
    .rdata_i   (tbl_rdata_i),
    .rd_o      (tbl_rd_o),
    .addr_o    (tbl_addr_o),
    .landing_o (landing),
    .hvalid_o  (handler_valid_o),
    .haddr_o   (handler_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      save_req_o   <= 1'b0;
      supervisor_o <= 1'b0;
      iack_o       <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            save_req_o <= 1'b1;
            st_q       <= ST_SAVE;
          end
        end
        ST_SAVE: begin
          if (save_done_i) begin
            save_req_o   <= 1'b0;
            supervisor_o <= 1'b1;
            iack_o       <= 1'b1;
            st_q         <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (win_done) begin
            iack_o <= 1'b0;
            st_q   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (landing) begin
            st_q <= ST_SERVE;
          end
        end
        ST_SERVE: begin
          if (rti_i) begin
            supervisor_o <= 1'b0;
            st_q         <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vack_ctrl_chk.sv
module vack_ctrl_chk #(
  parameter int unsigned ACK_LIMIT = 16
) (
  input logic clk,
  input logic rst,
  input logic insn_done_i,
  input logic rti_i,
  input logic save_req_o,
  input logic supervisor_o,
  input logic iack_o,
  input logic tbl_rd_o,
  input logic handler_valid_o
);

  localparam int unsigned RW = $clog2(ACK_LIMIT + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !iack_o) begin
      run_q <= '0;
    end else if (run_q != {RW{1'b1}}) begin
      run_q <= run_q + RW'(1);
    end
  end

  assert_accept_on_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(save_req_o) |-> $past(insn_done_i));

  assert_ack_in_supervisor_R4: assert property (@(posedge clk) disable iff (rst)
    iack_o |-> supervisor_o);

  assert_ack_window_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    iack_o |-> (run_q < RW'(ACK_LIMIT)));

  assert_read_follows_ack_R7: assert property (@(posedge clk) disable iff (rst)
    tbl_rd_o |-> $past(iack_o));

  assert_read_single_R7: assert property (@(posedge clk) disable iff (rst)
    tbl_rd_o |=> !tbl_rd_o);

  assert_handler_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    handler_valid_o |-> $past(tbl_rd_o, 2));

  assert_handler_single_R8: assert property (@(posedge clk) disable iff (rst)
    handler_valid_o |=> !handler_valid_o);

  assert_mode_drop_needs_rti_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(supervisor_o) |-> $past(rti_i));

endmodule

bind vack_ctrl vack_ctrl_chk #(.ACK_LIMIT(ACK_LIMIT)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .insn_done_i     (insn_done_i),
  .rti_i           (rti_i),
  .save_req_o      (save_req_o),
  .supervisor_o    (supervisor_o),
  .iack_o          (iack_o),
  .tbl_rd_o        (tbl_rd_o),
  .handler_valid_o (handler_valid_o)
);

// File: tb/vack_ctrl_tb_top.sv
`timescale 1ns/1ps
module vack_ctrl_tb_top;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [7:0]  SPUR = 8'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req_i = 1'b0;
  logic        insn_done_i = 1'b0;
  logic        save_done_i = 1'b0;
  logic        iack_valid_i = 1'b0;
  logic [7:0]  iack_vec_i = 8'h00;
  logic        rti_i = 1'b0;
  logic        save_req_o, supervisor_o, iack_o, tbl_rd_o, handler_valid_o;
  logic [31:0] tbl_addr_o, handler_addr_o;
  logic [31:0] tbl_rdata = 32'h0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vack_ctrl dut_i (
    .clk             (clk),
    .rst             (rst),
    .irq_req_i       (irq_req_i),
    .insn_done_i     (insn_done_i),
    .save_req_o      (save_req_o),
    .save_done_i     (save_done_i),
    .supervisor_o    (supervisor_o),
    .iack_o          (iack_o),
    .iack_valid_i    (iack_valid_i),
    .iack_vec_i      (iack_vec_i),
    .tbl_rd_o        (tbl_rd_o),
    .tbl_addr_o      (tbl_addr_o),
    .tbl_rdata_i     (tbl_rdata),
    .handler_valid_o (handler_valid_o),
    .handler_addr_o  (handler_addr_o),
    .rti_i           (rti_i)
  );

  function automatic logic [31:0] entry_of(input logic [31:0] a);
    return 32'h8000_0000 ^ (a << 4) ^ 32'h0000_0007;
  endfunction

  // Vector table model with one cycle read latency.
  always_ff @(posedge clk) begin
    if (tbl_rd_o) tbl_rdata <= entry_of(tbl_addr_o);
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_accept();
    insn_done_i = 1'b1; tick(); insn_done_i = 1'b0;
    chk("R3", "save_req after boundary", save_req_o, 1);
  endtask

  task automatic do_save();
    save_done_i = 1'b1; tick(); save_done_i = 1'b0;
    chk("R4", "save_req dropped", save_req_o, 0);
    chk("R4", "supervisor", supervisor_o, 1);
    chk("R4", "iack", iack_o, 1);
  endtask

  task automatic check_fetch(input logic [7:0] v);
    logic [31:0] ea;
    ea = BASE + ({24'h0, v} << 2);
    chk("R7", "tbl_rd", tbl_rd_o, 1);
    chk("R7", "tbl_addr", tbl_addr_o, ea);
    tick();
    chk("R7", "tbl_rd single", tbl_rd_o, 0);
    chk("R8", "handler early", handler_valid_o, 0);
    tick();
    chk("R8", "handler_valid", handler_valid_o, 1);
    chk("R8", "handler_addr", handler_addr_o, entry_of(ea));
    tick();
    chk("R8", "handler single", handler_valid_o, 0);
  endtask

  task automatic answer(input logic [7:0] v, input int d);
    repeat (d) tick();
    iack_valid_i = 1'b1; iack_vec_i = v; tick();
    iack_valid_i = 1'b0;
    chk("R5", "iack released", iack_o, 0);
    check_fetch(v);
  endtask

  task automatic do_rti();
    rti_i = 1'b1; tick(); rti_i = 1'b0;
    chk("R10", "user mode after rti", supervisor_o, 0);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1", "save_req in reset", save_req_o, 0);
    chk("R1", "iack in reset", iack_o, 0);
    rst = 1'b0; tick();
    chk("R1", "outputs after reset",
        {27'h0, save_req_o, iack_o, tbl_rd_o, handler_valid_o, supervisor_o}, 0);
  endtask

  task automatic t_boundary_and_record();
    irq_req_i = 1'b1; repeat (4) tick();
    chk("R3", "no accept without boundary", save_req_o, 0);
    irq_req_i = 1'b0; repeat (2) tick();
    chk("R3", "still waiting", save_req_o, 0);
    do_accept();  // R2: the dropped pulse was remembered
    repeat (3) tick();
    chk("R3", "save_req held", save_req_o, 1);
    do_save();
    answer(8'h23, 3);
    do_rti();
  endtask

  task automatic t_timeout();
    int n;
    irq_req_i = 1'b1;
    do_accept();  // same-cycle request and boundary
    irq_req_i = 1'b0;
    do_save();
    n = 0;
    while (iack_o && n < 40) begin n++; tick(); end
    chk("R6", "ack cycles before timeout", n, 16);
    check_fetch(SPUR);
    do_rti();
  endtask

  task automatic t_answer_on_last_cycle();
    irq_req_i = 1'b1; tick(); irq_req_i = 1'b0;
    do_accept();
    do_save();
    answer(8'hFF, 15);  // R6: answer on 16th cycle wins, R7 top entry
    do_rti();
  endtask

  task automatic t_mask();
    irq_req_i = 1'b1; do_accept(); irq_req_i = 1'b0;
    do_save();
    irq_req_i = 1'b1; tick(); irq_req_i = 1'b0;  // during acknowledge
    answer(8'h05, 2);
    do_rti();
    insn_done_i = 1'b1; tick(); insn_done_i = 1'b0;
    chk("R9", "masked request dropped", save_req_o, 0);
    tick();
    chk("R9", "still idle", save_req_o, 0);
  endtask

  task automatic t_rti_ignored_and_service_capture();
    rti_i = 1'b1; tick(); rti_i = 1'b0;
    chk("R11", "rti idle mode", supervisor_o, 0);
    chk("R11", "rti idle no start", save_req_o, 0);
    irq_req_i = 1'b1; do_accept(); irq_req_i = 1'b0;
    do_save();
    rti_i = 1'b1; tick(); rti_i = 1'b0;
    chk("R11", "rti in ack mode", supervisor_o, 1);
    chk("R11", "rti in ack iack", iack_o, 1);
    answer(8'h40, 0);
    irq_req_i = 1'b1; tick(); irq_req_i = 1'b0;  // recorded in service
    do_rti();
    chk("R10", "no start before boundary", save_req_o, 0);
    do_accept();  // R2: service-time request accepted
    do_save();
    answer(8'h41, 1);
  endtask

  task automatic t_level_reeval();
    irq_req_i = 1'b1;  // held through return
    do_rti();
    chk("R10", "held level waits for boundary", save_req_o, 0);
    do_accept();
    irq_req_i = 1'b0;
    do_save();
    answer(8'h02, 4);
    do_rti();
  endtask

  initial begin
    t_reset();
    t_boundary_and_record();
    t_timeout();
    t_answer_on_last_cycle();
    t_mask();
    t_rti_ignored_and_service_capture();
    t_level_reeval();
    repeat (3) tick();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule